// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This block multiplies two 16-bit operands and combines the 32-bit product with one of two 40-bit accumulators. The product can replace the accumulator, be added to it, or be subtracted from it. Each operand is read as signed or unsigned on its own, so all four signedness pairings use the same datapath. In fractional mode the product is moved up by one bit so that two 1.15 values yield a 1.31 result. Integer mode applies no shift.

Each accumulator holds an 8-bit guard byte in bits 39:32, a middle word in bits 31:16 and a low word in bits 15:0. The guard bits let a long run of full-scale accumulations build up without wrapping. A per-accumulator overflow flag shows when the value no longer fits a 32-bit signed word. A saturate operation clamps an overflowed accumulator to the nearest 32-bit full-scale value. A clear operation empties it. Every operation acts on one accumulator, chosen per operation. The result is visible one clock after the operation is presented.

Top module: `dual_acc_mac`

## Requirements
- R1: After reset both accumulators read zero and both overflow flags are clear.
- R2: Operation code 0 (multiply) loads the selected accumulator with the product, sign-extended to 40 bits. Each operand is taken as two's complement when its signed input is 1 and as unsigned when it is 0. With fractional mode off, no shift is applied.
- R3: With fractional mode on, the product is shifted left by one bit before it is used.
- R4: Operation code 1 (multiply-add) loads the selected accumulator with its old value plus the aligned product, modulo 2^40.
- R5: Operation code 2 (multiply-subtract) loads the selected accumulator with its old value minus the aligned product, modulo 2^40.
- R6: When acc_sel is 0 the operation acts on accumulator 0, and when it is 1 it acts on accumulator 1. The other accumulator and its flag do not change.
- R7: When round is 1 during codes 0 to 2, 0x8000 is added to the 40-bit result and bits 15:0 are then cleared.
- R8: Operation code 3 (clear) zeroes the selected accumulator and its overflow flag.
- R9: After codes 0 to 2, the overflow flag of the written accumulator is 1 exactly when bits 39 to 31 of its new value are not all equal.
- R10: Operation code 4 (saturate) acts only when the selected flag is set. It then loads 0x007FFFFFFF if bit 39 is 0, or 0xFF80000000 if bit 39 is 1, and clears the flag. When the flag is clear, the accumulator is left unchanged.
- R11: 255 multiply-adds of the signed fractional full-scale product (0x8000 by 0x8000) accumulate to 0x7F80000000 without wrapping.
- R12: Operation codes 5 to 7, and any cycle with op_valid low, change neither accumulator nor either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 clear, 4 saturate |
| round | input | 1 | Round the result of codes 0 to 2 |
| x_signed | input | 1 | X operand is two's complement |
| y_signed | input | 1 | Y operand is two's complement |
| frac_mode | input | 1 | Shift the product left by one bit |
| acc_sel | input | 1 | Target accumulator |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| ovf0 | output | 1 | Overflow flag of accumulator 0 |
| ovf1 | output | 1 | Overflow flag of accumulator 1 |

## Verification
Every operation is sampled at one rising edge, and its result is visible on the accumulator and flag outputs straight after that edge. There is no extra pipeline stage. The bench drives each operation on a falling edge and drops op_valid on the next falling edge. It compares all four outputs against its arithmetic model at that point, one cycle after the stimulus. Because successive operations build on the model's running accumulators, any error in an earlier step is still visible in later comparisons.

// File: rtl/dual_acc_mac.sv
module dual_acc_mac #(
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic             round,
  input  logic             x_signed,
  input  logic             y_signed,
  input  logic             frac_mode,
  input  logic             acc_sel,
  input  logic [DW-1:0]    x_in,
  input  logic [DW-1:0]    y_in,
  output logic [2*DW+GW-1:0] acc0,
  output logic [2*DW+GW-1:0] acc1,
  output logic             ovf0,
  output logic             ovf1
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;
  localparam int EW = DW + 1;
  localparam int XW = AW - 2 * EW;
  localparam logic [2:0] OP_MUL = 3'd0;
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_CLR = 3'd3;
  localparam logic [2:0] OP_SAT = 3'd4;
  localparam logic [AW-1:0] SAT_POS = {{(GW+1){1'b0}}, {(PW-1){1'b1}}};
  localparam logic [AW-1:0] SAT_NEG = ~SAT_POS;
  localparam logic [AW-1:0] RND_ADD = {{(AW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
  localparam logic [AW-1:0] LOW_CLR = {{(AW-DW){1'b1}}, {DW{1'b0}}};

  function automatic logic out_of_range(input logic [AW-1:0] v);
    return !((&v[AW-1:PW-1]) || !(|v[AW-1:PW-1]));
  endfunction

  logic [AW-1:0] acc_q [2];
  logic          ovf_q [2];

  logic signed [EW-1:0]   x_ext, y_ext;
  logic signed [2*EW-1:0] prod;
  logic [AW-1:0]          prod_ext, prod_al, cur, sum, res;
  logic                   cur_ovf;

  assign x_ext    = {x_signed & x_in[DW-1], x_in};
  assign y_ext    = {y_signed & y_in[DW-1], y_in};
  assign prod     = x_ext * y_ext;
  assign prod_ext = {{XW{prod[2*EW-1]}}, prod};
  assign prod_al  = frac_mode ? (prod_ext << 1) : prod_ext;
  assign cur      = acc_q[acc_sel];
  assign cur_ovf  = ovf_q[acc_sel];

  always_comb begin
    case (op_code)
      OP_ADD:  sum = cur + prod_al;
      OP_SUB:  sum = cur - prod_al;
      default: sum = prod_al;
    endcase
  end

  assign res = round ? ((sum + RND_ADD) & LOW_CLR) : sum;

  logic          wr;
  logic [AW-1:0] nxt_val;
  logic          nxt_ovf;

  always_comb begin
    wr      = 1'b0;
    nxt_val = cur;
    nxt_ovf = cur_ovf;
    if (op_valid) begin
      case (op_code)
        OP_MUL, OP_ADD, OP_SUB: begin
          wr      = 1'b1;
          nxt_val = res;
          nxt_ovf = out_of_range(res);
        end
        OP_CLR: begin
          wr      = 1'b1;
          nxt_val = '0;
          nxt_ovf = 1'b0;
        end
        OP_SAT: begin
          wr = cur_ovf;
          nxt_val = cur[AW-1] ? SAT_NEG : SAT_POS;
          nxt_ovf = 1'b0;
        end
        default: wr = 1'b0;
      endcase
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[i] <= '0;
        ovf_q[i] <= 1'b0;
      end else if (wr && (acc_sel == i[0])) begin
        acc_q[i] <= nxt_val;
        ovf_q[i] <= nxt_ovf;
      end
    end

    // R6
    other_acc_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && acc_sel != i[0]) |=> ($stable(acc_q[i]) && $stable(ovf_q[i])));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid || op_code > OP_SAT) |=> ($stable(acc_q[i]) && $stable(ovf_q[i])));
    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CLR && acc_sel == i[0]) |=> (acc_q[i] == '0 && !ovf_q[i]));
    // R9
    ovf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q[i] == out_of_range(acc_q[i]));
    // R10
    sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SAT && acc_sel == i[0] && ovf_q[i])
      |=> ((acc_q[i] == SAT_POS || acc_q[i] == SAT_NEG) && !ovf_q[i]));
    // R7
    round_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && round && op_code <= OP_SUB && acc_sel == i[0])
      |=> (acc_q[i][DW-1:0] == '0));
  end

  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];
  assign ovf0 = ovf_q[0];
  assign ovf1 = ovf_q[1];
endmodule

// File: tb/tb_dual_acc_mac.sv
module tb_dual_acc_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        round = 1'b0, x_signed = 1'b0, y_signed = 1'b0, frac_mode = 1'b0, acc_sel = 1'b0;
  logic [15:0] x_in = '0, y_in = '0;
  logic [39:0] acc0, acc1;
  logic        ovf0, ovf1;

  int checks = 0;
  int errors = 0;
  logic [39:0] m_acc [2];
  logic        m_ovf [2];

  always #2.5 clk = ~clk;

  dual_acc_mac dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .round(round),
    .x_signed(x_signed), .y_signed(y_signed), .frac_mode(frac_mode), .acc_sel(acc_sel),
    .x_in(x_in), .y_in(y_in), .acc0(acc0), .acc1(acc1), .ovf0(ovf0), .ovf1(ovf1)
  );

  function automatic logic oor(input logic [39:0] v);
    return !((v[39:31] == 9'h000) || (v[39:31] == 9'h1FF));
  endfunction

  function automatic logic [39:0] aligned(input logic [15:0] x, input logic [15:0] y,
                                          input logic xs, input logic ys, input logic fr);
    longint xv, yv, p;
    xv = xs ? longint'($signed(x)) : longint'(x);
    yv = ys ? longint'($signed(y)) : longint'(y);
    p = xv * yv;
    if (fr) p = p * 2;
    return p[39:0];
  endfunction

  task automatic chk40(input string tag, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk40(tag, acc0, m_acc[0]);
    chk40(tag, acc1, m_acc[1]);
    chk40(tag, {39'd0, ovf0}, {39'd0, m_ovf[0]});
    chk40(tag, {39'd0, ovf1}, {39'd0, m_ovf[1]});
  endtask

  task automatic do_op(input logic [2:0] op, input logic rnd, input logic xs, input logic ys,
                       input logic fr, input logic sel, input logic [15:0] x, input logic [15:0] y,
                       input string tag);
    logic [39:0] p, r;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; round = rnd; x_signed = xs; y_signed = ys;
    frac_mode = fr; acc_sel = sel; x_in = x; y_in = y;
    p = aligned(x, y, xs, ys, fr);
    case (op)
      3'd0, 3'd1, 3'd2: begin
        r = (op == 3'd0) ? p : (op == 3'd1) ? m_acc[sel] + p : m_acc[sel] - p;
        if (rnd) r = (r + 40'h8000) & ~40'hFFFF;
        m_acc[sel] = r;
        m_ovf[sel] = oor(r);
      end
      3'd3: begin m_acc[sel] = '0; m_ovf[sel] = 1'b0; end
      3'd4: if (m_ovf[sel]) begin
        m_acc[sel] = m_acc[sel][39] ? 40'hFF80000000 : 40'h007FFFFFFF;
        m_ovf[sel] = 1'b0;
      end
      default: ;
    endcase
    @(negedge clk);
    op_valid = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pat [7];
    pat[0] = 16'h0000; pat[1] = 16'h0001; pat[2] = 16'h7FFF; pat[3] = 16'h8000;
    pat[4] = 16'hFFFF; pat[5] = 16'h1234; pat[6] = 16'hABCD;
    m_acc[0] = '0; m_acc[1] = '0; m_ovf[0] = 1'b0; m_ovf[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;

    // R2 signed 0xFFFF x unsigned 0xFFFF integer: -65535
    do_op(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, "R2 su");
    chk40("R2 su const", acc0, 40'hFFFFFF0001);
    // R3 fractional 0x4000*0x4000 -> 0x20000000
    do_op(3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h4000, 16'h4000, "R3 frac");
    chk40("R3 frac const", acc1, 40'h0020000000);
    // R7 rounding
    do_op(3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h8000, "R7 round");
    chk40("R7 round const", acc0, 40'h0000010000);

    // R2 R3 R4 R5 R6 R7 R9 sweep
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++)
          for (int o = 0; o < 4; o++)
            do_op((o == 3) ? 3'd0 : 3'(o), (o == 3), s[0], s[1], s[2], (a + b) % 2 == 1,
                  pat[a], pat[b], "R2 R3 R4 R5 R6 R7 R9 sweep");

    // R8 clear both
    do_op(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1111, 16'h2222, "R8 clear0");
    do_op(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1111, 16'h2222, "R8 clear1");
    chk40("R8 zero", acc0 | acc1, 40'd0);

    // R11 guard accumulation
    for (int k = 0; k < 255; k++)
      do_op(3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000, "R11 accumulate");
    chk40("R11 guard total", acc0, 40'h7F80000000);
    chk40("R9 ovf after guard", {39'd0, ovf0}, 40'd1);
    // R10 positive saturation
    do_op(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, "R10 sat pos");
    chk40("R10 sat pos const", acc0, 40'h007FFFFFFF);
    // R10 saturate without overflow: no change
    do_op(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, "R10 sat idle");
    chk40("R10 sat idle const", acc0, 40'h007FFFFFFF);
    // R10 negative saturation
    do_op(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, "R8 clear1b");
    do_op(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8000, 16'h8000, "R5 sub");
    do_op(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8000, 16'h8000, "R5 sub");
    chk40("R5 sub const", acc1, 40'hFF00000000);
    do_op(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, "R10 sat neg");
    chk40("R10 sat neg const", acc1, 40'hFF80000000);

    // R12 unused codes and idle cycles
    for (int c = 5; c < 8; c++)
      do_op(3'(c), 1'b1, 1'b1, 1'b1, 1'b1, c[0], 16'h7FFF, 16'h7FFF, "R12 unused code");
    @(negedge clk);
    op_code = 3'd1; acc_sel = 1'b1; x_in = 16'h7FFF; y_in = 16'h7FFF; op_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R12 idle");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule